// File: doc/BRIEF.md
# Four-Bit Stack Calculator Datapath

This block is the datapath of a small accumulator machine. One working register is combined each enabled clock with a second operand by a logic and arithmetic unit, and the result goes back into the register. The second operand is either a value typed on external switches or the entry on top of an eight-deep operand stack. A signed-overflow flag is registered at the same edge as the result.

The working register can be pushed onto the stack, and the top entry can be popped. For display, the block drives four outputs. The register value goes to an active-low seven-segment hex digit. The top stack entry is shown as raw bits. The stack occupancy is shown as a thermometer bar gauge. Debouncing, pads and output buffers sit outside the block.

Top module: `calc_core`

## Requirements
- R1: Driving `glb_rst_ni` low empties the stack and zeroes the accumulator and the overflow flag at once, with no clock edge needed. While reset is held, `acc_o`, `ovf_o`, `tos_o` and `gauge_o` all read 0.
- R2: While `ce_i` is low, a rising edge changes nothing. The accumulator, the flag and the stack hold whatever the opcode, `clr_i`, `push_i` and `pop_i` are.
- R3: On an edge with `ce_i` high and `clr_i` high, the accumulator and the flag become 0 whatever the opcode. The stack still obeys `push_i` and `pop_i` in that cycle.
- R4: `src_sel_i` = 1 picks `sw_i` as the operand, and `src_sel_i` = 0 picks the current top of stack. An empty stack supplies 0.
- R5: These opcodes load the named result and clear the flag: 000 (pass operand), 001 (acc AND operand), 010 (acc OR operand) and 011 (acc XOR operand).
- R6: Opcode 100 loads acc + operand and opcode 101 loads acc − operand, both modulo 16. The flag is set exactly when the result, read as a signed 4-bit value, overflows the two's-complement range −8..7.
- R7: Opcodes 110 and 111 leave the accumulator and the flag unchanged.
- R8: An enabled push stores the accumulator value from before the edge, and `tos_o` shows it after the edge. An enabled pop removes the top entry. Push and pop asserted together do nothing to the stack.
- R9: A push when 8 entries are stored is ignored. A pop when the stack is empty is ignored.
- R10: `gauge_o[i]` is 1 exactly when more than i entries are stored (i = 0..7).
- R11: `seg_n_o` is active low, with bit 6..0 = segments g,f,e,d,c,b,a. The lit sets are: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 all, 9 abcdfg, A abcefg, b cdefg, C adef, d bcdeg, E adefg, F aefg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| glb_rst_ni | input | 1 | Asynchronous global reset, active low |
| ce_i | input | 1 | Clock enable for register, flag and stack |
| clr_i | input | 1 | Synchronous clear of accumulator and flag |
| op_i | input | 3 | Operation code |
| src_sel_i | input | 1 | Operand select: 1 switches, 0 stack top |
| sw_i | input | 4 | Switch operand |
| push_i | input | 1 | Push accumulator onto stack |
| pop_i | input | 1 | Pop top stack entry |
| acc_o | output | 4 | Working register value |
| seg_n_o | output | 7 | Active-low segments g..a of the accumulator digit |
| tos_o | output | 4 | Top stack entry, 0 when empty |
| gauge_o | output | 8 | Thermometer gauge of stack occupancy |
| ovf_o | output | 1 | Registered signed overflow flag |

## Verification
The bench builds the block with its default parameters: a 4-bit datapath and a stack 8 entries deep. At the 4-bit width the whole digit range can be swept through the display, and every signed-overflow boundary can be reached with short operands. The shallow stack lets a single run push past full and pop past empty within a few dozen cycles, with the occupancy gauge checked at every step along the way.

// File: rtl/calc_pkg.sv
package calc_pkg;

  typedef enum logic [2:0] {
    OP_PASS = 3'b000,
    OP_AND  = 3'b001,
    OP_OR   = 3'b010,
    OP_XOR  = 3'b011,
    OP_ADD  = 3'b100,
    OP_SUB  = 3'b101,
    OP_HLDA = 3'b110,
    OP_HLDB = 3'b111
  } calc_op_e;

  // Lit segments in g..a order, active high; callers invert for the pins.
  function automatic logic [6:0] hex_lit(input logic [3:0] v);
    logic [6:0] lit;
    case (v)
      4'h0:    lit = 7'b0111111;
      4'h1:    lit = 7'b0000110;
      4'h2:    lit = 7'b1011011;
      4'h3:    lit = 7'b1001111;
      4'h4:    lit = 7'b1100110;
      4'h5:    lit = 7'b1101101;
      4'h6:    lit = 7'b1111101;
      4'h7:    lit = 7'b0000111;
      4'h8:    lit = 7'b1111111;
      4'h9:    lit = 7'b1101111;
      4'hA:    lit = 7'b1110111;
      4'hB:    lit = 7'b1111100;
      4'hC:    lit = 7'b0111001;
      4'hD:    lit = 7'b1011110;
      4'hE:    lit = 7'b1111001;
      default: lit = 7'b1110001;
    endcase
    return lit;
  endfunction

endpackage

// File: rtl/calc_alu.sv
module calc_alu
  import calc_pkg::*;
#(
  parameter int W = 4
) (
  input  calc_op_e     op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o,
  output logic         load_o
);

  // {overflow, sum}
  function automatic logic [W:0] add_w(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] s;
    s = a + b;
    return {(a[W-1] == b[W-1]) && (s[W-1] != a[W-1]), s};
  endfunction

  // {overflow, a - b}
  function automatic logic [W:0] sub_w(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] d;
    d = a - b;
    return {(a[W-1] != b[W-1]) && (d[W-1] != a[W-1]), d};
  endfunction

  always_comb begin
    res_o  = acc_i;
    ovf_o  = 1'b0;
    load_o = 1'b1;
    case (op_i)
      OP_PASS: res_o = opnd_i;
      OP_AND:  res_o = acc_i & opnd_i;
      OP_OR:   res_o = acc_i | opnd_i;
      OP_XOR:  res_o = acc_i ^ opnd_i;
      OP_ADD:  {ovf_o, res_o} = add_w(acc_i, opnd_i);
      OP_SUB:  {ovf_o, res_o} = sub_w(acc_i, opnd_i);
      default: load_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/calc_stack.sv
module calc_stack #(
  parameter int W     = 4,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     wr_data_i,
  output logic [W-1:0]     tos_o,
  output logic [DEPTH-1:0] gauge_o
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count_q;
  logic [W-1:0]     mem_q [DEPTH];

  // Named stack events, used by the counter and by the assertions.
  logic is_full, is_empty, push_req, pop_req;
  logic push_fire, pop_fire, push_drop, pop_drop;

  assign is_full   = (count_q == FULL_CNT);
  assign is_empty  = (count_q == '0);
  assign push_req  = ce_i && push_i && !pop_i;
  assign pop_req   = ce_i && pop_i && !push_i;
  assign push_fire = push_req && !is_full;
  assign pop_fire  = pop_req && !is_empty;
  assign push_drop = push_req && is_full;
  assign pop_drop  = pop_req && is_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= '0;
    else if (push_fire) count_q <= count_q + 1'b1;
    else if (pop_fire)  count_q <= count_q - 1'b1;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[e] <= '0;
      else if (push_fire && (count_q == CNT_W'(e)))
        mem_q[e] <= wr_data_i;
    end
    assign gauge_o[e] = (count_q > CNT_W'(e));
  end

  always_comb begin
    tos_o = '0;
    for (int e = 0; e < DEPTH; e++)
      if (count_q == CNT_W'(e + 1)) tos_o = mem_q[e];
  end

  // R8: a pushed value appears on top after the edge.
  assert_push_lands_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_fire |=> (tos_o == $past(wr_data_i)));
  // R9: a push into a full stack leaves it untouched.
  assert_full_push_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_drop |=> ($stable(count_q) && $stable(tos_o)));
  // R9: a pop from an empty stack keeps it empty.
  assert_empty_pop_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_drop |=> (gauge_o == '0) && (tos_o == '0));
  // R10: the gauge is a thermometer whose length is the occupancy.
  assert_gauge_thermo_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({1'b0, gauge_o} + {{DEPTH{1'b0}}, 1'b1}) && ($countones(gauge_o) == int'(count_q)));
  // R4: an empty stack supplies zero.
  assert_empty_top_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_empty |-> (tos_o == '0));

endmodule

// File: rtl/calc_seg7.sv
module calc_seg7
  import calc_pkg::*;
(
  input  logic [3:0] val_i,
  output logic [6:0] seg_n_o
);

  assign seg_n_o = ~hex_lit(val_i);

  // R11: digit 8 lights every segment, digit 1 lights only b and c.
  always_comb begin
    if (val_i == 4'h8) assert_eight_all_lit_R11: assert (seg_n_o == 7'b0000000);
    if (val_i == 4'h1) assert_one_bc_R11: assert (seg_n_o == 7'b1111001);
  end

endmodule

// File: rtl/calc_core.sv
module calc_core
  import calc_pkg::*;
#(
  parameter int DATA_W      = 4,
  parameter int STACK_DEPTH = 8
) (
  input  logic                   clk_i,
  input  logic                   glb_rst_ni,
  input  logic                   ce_i,
  input  logic                   clr_i,
  input  logic [2:0]             op_i,
  input  logic                   src_sel_i,
  input  logic [DATA_W-1:0]      sw_i,
  input  logic                   push_i,
  input  logic                   pop_i,
  output logic [DATA_W-1:0]      acc_o,
  output logic [6:0]             seg_n_o,
  output logic [DATA_W-1:0]      tos_o,
  output logic [STACK_DEPTH-1:0] gauge_o,
  output logic                   ovf_o
);

  logic [DATA_W-1:0] acc_q, opnd, alu_res;
  logic              ovf_q, alu_ovf, alu_load;
  calc_op_e          op;

  assign op   = calc_op_e'(op_i);
  assign opnd = src_sel_i ? sw_i : tos_o;

  calc_alu #(.W(DATA_W)) u_alu (
    .op_i   (op),
    .acc_i  (acc_q),
    .opnd_i (opnd),
    .res_o  (alu_res),
    .ovf_o  (alu_ovf),
    .load_o (alu_load)
  );

  always_ff @(posedge clk_i or negedge glb_rst_ni) begin
    if (!glb_rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (ce_i) begin
      if (clr_i) begin
        acc_q <= '0;
        ovf_q <= 1'b0;
      end else if (alu_load) begin
        acc_q <= alu_res;
        ovf_q <= alu_ovf;
      end
    end
  end

  // The stack records the accumulator as it stood before this edge.
  calc_stack #(.W(DATA_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk_i     (clk_i),
    .rst_ni    (glb_rst_ni),
    .ce_i      (ce_i),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .wr_data_i (acc_q),
    .tos_o     (tos_o),
    .gauge_o   (gauge_o)
  );

  calc_seg7 u_seg7 (
    .val_i   (acc_q[3:0]),
    .seg_n_o (seg_n_o)
  );

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;

  // R1: reset holds everything at zero.
  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !glb_rst_ni |-> (acc_o == '0) && !ovf_o && (gauge_o == '0));
  // R2: disabled clock holds register and flag.
  assert_ce_hold_R2: assert property (@(posedge clk_i) disable iff (!glb_rst_ni)
    !ce_i |=> $stable(acc_o) && $stable(ovf_o) && $stable(gauge_o));
  // R3: synchronous clear wins over any opcode.
  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!glb_rst_ni)
    (ce_i && clr_i) |=> (acc_o == '0) && !ovf_o);
  // R5: logic and pass opcodes leave no overflow.
  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!glb_rst_ni)
    (ce_i && !clr_i && !op_i[2]) |=> !ovf_o);
  // R7: hold opcodes keep register and flag.
  assert_hold_op_R7: assert property (@(posedge clk_i) disable iff (!glb_rst_ni)
    (ce_i && !clr_i && (op_i[2:1] == 2'b11)) |=> $stable(acc_o) && $stable(ovf_o));
  // R4: switch operand passes straight through.
  assert_sw_pass_R4: assert property (@(posedge clk_i) disable iff (!glb_rst_ni)
    (ce_i && !clr_i && src_sel_i && (op_i == 3'b000)) |=> (acc_o == $past(sw_i)));

endmodule

// File: tb/calc_core_tb.sv
module calc_core_tb_top;

  localparam logic [2:0] P_PASS = 3'd0, P_AND = 3'd1, P_OR = 3'd2, P_XOR = 3'd3,
                         P_ADD = 3'd4, P_SUB = 3'd5, P_HLA = 3'd6, P_HLB = 3'd7;
  localparam logic SW = 1'b1, TS = 1'b0;

  // Per-segment sets of digits that light it (bit k = digit k), a..g.
  localparam logic [15:0] MASK [7] = '{16'hD7ED, 16'h279F, 16'h2FFB, 16'h7B6D,
                                       16'hFD45, 16'hDF71, 16'hEF7C};

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, clr = 1'b0, sel = 1'b0, push = 1'b0, pop = 1'b0;
  logic [2:0] op = 3'd6;
  logic [3:0] sw = 4'd0;
  logic [3:0] acc, tos;
  logic [6:0] seg_n;
  logic [7:0] gauge;
  logic       ovf;

  always #5 clk = ~clk;

  calc_core dut_i (
    .clk_i(clk), .glb_rst_ni(rst_n), .ce_i(ce), .clr_i(clr), .op_i(op),
    .src_sel_i(sel), .sw_i(sw), .push_i(push), .pop_i(pop),
    .acc_o(acc), .seg_n_o(seg_n), .tos_o(tos), .gauge_o(gauge), .ovf_o(ovf)
  );

  typedef struct {
    logic [3:0] acc; logic ovf; logic [3:0] tos; logic [7:0] gauge; logic [6:0] seg; string req;
  } exp_t;

  exp_t       sb_q[$];
  logic [3:0] m_stk[$];
  logic [3:0] m_acc = 4'd0;
  logic       m_ovf = 1'b0;
  int n_vec = 0, n_bad = 0;

  function automatic logic [6:0] seg_of(input logic [3:0] v);
    logic [6:0] s;
    for (int k = 0; k < 7; k++) s[k] = ~MASK[k][v];
    return s;
  endfunction

  function automatic int sval(input logic [3:0] v);
    return (v >= 8) ? int'(v) - 16 : int'(v);
  endfunction

  function automatic exp_t snap(input string req);
    exp_t e;
    e.acc = m_acc; e.ovf = m_ovf;
    e.tos = (m_stk.size() == 0) ? 4'd0 : m_stk[$];
    e.gauge = 8'((1 << m_stk.size()) - 1);
    e.seg = seg_of(m_acc); e.req = req;
    return e;
  endfunction

  task automatic compare(input exp_t e);
    n_vec++;
    if (acc !== e.acc || ovf !== e.ovf || tos !== e.tos || gauge !== e.gauge || seg_n !== e.seg) begin
      n_bad++;
      $display("FAIL %s: acc=%h ovf=%b tos=%h gauge=%b seg=%b expected acc=%h ovf=%b tos=%h gauge=%b seg=%b",
               e.req, acc, ovf, tos, gauge, seg_n, e.acc, e.ovf, e.tos, e.gauge, e.seg);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outcome.
  task automatic step(input logic c, input logic cl, input logic [2:0] o, input logic s,
                      input logic [3:0] d, input logic pu, input logic po, input string req);
    logic [3:0] opnd, old;
    int r;
    @(negedge clk);
    ce = c; clr = cl; op = o; sel = s; sw = d; push = pu; pop = po;
    old  = m_acc;
    opnd = s ? d : ((m_stk.size() == 0) ? 4'd0 : m_stk[$]);
    if (c) begin
      if (cl) begin m_acc = 0; m_ovf = 0; end
      else case (o)
        P_PASS: begin m_acc = opnd; m_ovf = 0; end
        P_AND:  begin m_acc = old & opnd; m_ovf = 0; end
        P_OR:   begin m_acc = old | opnd; m_ovf = 0; end
        P_XOR:  begin m_acc = old ^ opnd; m_ovf = 0; end
        P_ADD:  begin r = sval(old) + sval(opnd); m_acc = 4'(r); m_ovf = (r > 7 || r < -8); end
        P_SUB:  begin r = sval(old) - sval(opnd); m_acc = 4'(r); m_ovf = (r > 7 || r < -8); end
        default: ;
      endcase
      if (pu && !po && m_stk.size() < 8) m_stk.push_back(old);
      else if (po && !pu && m_stk.size() > 0) void'(m_stk.pop_back());
    end
    sb_q.push_back(snap(req));
  endtask

  // Monitor: pops one expected item per clock, after the edge settles.
  initial forever begin
    @(posedge clk); #2;
    if (sb_q.size() > 0) compare(sb_q.pop_front());
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 compare(snap("R1 reset"));
    @(negedge clk) rst_n = 1'b1;
    // R4 R5 R7 R8: load, push, operand from stack
    step(1,0,P_PASS,SW,4'h5,0,0,"R5 pass");
    step(1,0,P_HLA ,SW,4'h3,1,0,"R8 push / R7 hold");
    step(1,0,P_PASS,SW,4'h9,0,0,"R5 pass");
    step(1,0,P_XOR ,TS,4'h0,0,0,"R4 xor stack");
    step(1,0,P_AND ,SW,4'h6,0,0,"R5 and");
    step(1,0,P_OR  ,TS,4'h0,0,0,"R5 or stack");
    // R6 overflow corners
    step(1,0,P_PASS,SW,4'h7,0,0,"R5 pass");
    step(1,0,P_ADD ,SW,4'h1,0,0,"R6 add ovf");
    step(1,0,P_HLB ,SW,4'h2,0,0,"R7 hold keeps ovf");
    step(1,0,P_ADD ,SW,4'hF,0,0,"R6 add neg ovf");
    step(1,0,P_PASS,SW,4'h8,0,0,"R5 pass clears ovf");
    step(1,0,P_SUB ,SW,4'h1,0,0,"R6 sub ovf");
    step(1,0,P_SUB ,SW,4'h3,0,0,"R6 sub");
    step(1,0,P_ADD ,SW,4'h2,0,0,"R6 add");
    step(1,0,P_ADD ,SW,4'h3,0,0,"R6 add pos ovf");
    step(1,0,P_SUB ,TS,4'h0,0,0,"R6 sub stack");
    step(1,0,P_AND ,SW,4'hF,0,0,"R5 and clears ovf");
    // R2 disabled clock, R3 clear
    step(0,0,P_ADD ,SW,4'h3,1,0,"R2 ce low");
    step(0,1,P_PASS,SW,4'h0,0,1,"R2 ce low");
    step(1,1,P_ADD ,SW,4'h3,1,0,"R3 clear, push proceeds");
    // R9 R10 fill past full
    for (int k = 0; k < 10; k++) step(1,0,P_PASS,SW,4'(k+1),1,0,"R9 R10 fill");
    step(1,0,P_HLA ,SW,4'h0,1,1,"R8 push+pop ignored");
    for (int k = 0; k < 10; k++) step(1,0,P_HLA,SW,4'h0,0,1,"R9 R10 drain");
    step(1,0,P_PASS,TS,4'h0,0,0,"R4 empty stack operand");
    // R11 display sweep
    for (int v = 0; v < 16; v++) step(1,0,P_PASS,SW,4'(v),0,0,"R11 digit");
    step(1,0,P_HLA ,SW,4'h0,1,0,"R8 push");
    step(0,0,P_HLA ,SW,4'h0,0,0,"R2 idle");
    // R1 asynchronous reset mid-cycle
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    m_acc = 0; m_ovf = 0; m_stk.delete();
    compare(snap("R1 async reset"));
    @(negedge clk) rst_n = 1'b1;
    step(1,0,P_ADD ,SW,4'h4,0,0,"R6 add after reset");
    step(0,0,P_HLA ,SW,4'h0,0,0,"R2 idle");
    repeat (3) @(posedge clk);
    #3 finish_run();
  end

endmodule